// File: doc/BRIEF.md
# Banked Register Address Pointer

This block produces the register address for a serially accessed register file that holds two 8-bit ports, A and B. A serial front end hands it the register address byte at the start of each transaction. After that, the block moves the address on by one step for every completed data byte. The register storage and the serial protocol sit outside the block. The block only decides which location each byte reaches, and whether that location exists.

A layout input selects one of two address maps:

- **Split map.** Each port owns its own region: port A at 00h–0Ah and port B at 10h–1Ah. The addresses 0Bh–0Fh form a hole between the two regions.
- **Paired map.** The A and B copies of each function sit next to each other at an even/odd address pair, so each pair reads as one 16-bit register. The map runs from 00h to 15h.

A hold-pointer input switches auto-increment off. With auto-increment off, the split map keeps hitting the same address. The paired map instead swaps between the two halves of the current pair.

Top module: `reg_addr_ptr`

## Requirements
- R1: During and right after reset (`rst` = 1, synchronous), `addr` is 00h and `addr_valid` is 1.
- R2: When `load` is 1 at a clock edge, `addr` equals `load_addr` after that edge. This holds even if `step` is also 1 at that edge.
- R3: Split map (`layout_split` = 1) with `hold_ptr` = 0: each `step` adds one to the address. The one exception is 0Ah, which is followed by 10h.
- R4: Split map with `hold_ptr` = 0: a `step` from 1Ah or from any higher address gives 00h.
- R5: Paired map (`layout_split` = 0) with `hold_ptr` = 0: each `step` adds one to the address. A `step` from 15h or from any higher address gives 00h.
- R6: Split map with `hold_ptr` = 1: a `step` leaves `addr` unchanged.
- R7: Paired map with `hold_ptr` = 1: a `step` inverts bit 0 of `addr`. For example, 12h→13h→12h, and 15h→14h.
- R8: `addr_valid` is 1 exactly when `addr` is a location of the map that was selected at the last clock edge. In the split map the valid locations are 00h–0Ah and 10h–1Ah. In the paired map they are 00h–15h, and this range includes the shared configuration aliases at 0Ah and 0Bh.
- R9: With `load` = 0 and `step` = 0, `addr` keeps its value. `addr_valid` still follows a change of `layout_split` one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start of transaction: take `load_addr` |
| load_addr | input | 8 | Register address byte received from the front end |
| step | input | 1 | Data byte completed: advance the pointer |
| layout_split | input | 1 | 1 = split map, 0 = paired map |
| hold_ptr | input | 1 | 1 = auto-increment disabled |
| addr | output | 8 | Current register address (registered) |
| addr_valid | output | 1 | Current address is a real location (registered) |

## Verification
The bench drives the split map across the 0Ah→10h jump. A design that merely increments would walk into the hole and flag 0Bh as invalid. The bench also drives both wrap points, 1Ah and 15h, and starts steps from addresses above each map's end. A design with an equality-only wrap would run off into unmapped space there.

With auto-increment off, the bench starts in both halves of a pair. A design that freezes the pointer in the paired map, or that only ever counts upward, would break the alternation. The bench also checks three more cases: that `load` wins over a simultaneous `step`, that the hole and the out-of-range addresses are flagged, and that a layout switch with no step re-evaluates validity for the address already held.

// File: rtl/rap_pkg.sv
package rap_pkg;
  typedef enum logic [1:0] {
    MOVE_HOLD   = 2'd0,
    MOVE_INC    = 2'd1,
    MOVE_TOGGLE = 2'd2
  } move_e;
endpackage

// File: rtl/rap_step.sv
module rap_step #(
  parameter int ADDR_W = 8,
  parameter int REGS_PER_PORT = 11,
  parameter int B_BASE = 16
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic              split,
  input  logic              hold,
  output logic [ADDR_W-1:0] nxt
);
  import rap_pkg::*;

  localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(REGS_PER_PORT - 1);
  localparam logic [ADDR_W-1:0] B_FIRST = ADDR_W'(B_BASE);
  localparam logic [ADDR_W-1:0] B_LAST  = ADDR_W'(B_BASE + REGS_PER_PORT - 1);
  localparam logic [ADDR_W-1:0] P_LAST  = ADDR_W'(2 * REGS_PER_PORT - 1);
  localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);

  move_e kind;

  // Pick the kind of move from the two mode bits.
  always_comb begin
    if (!hold)      kind = MOVE_INC;
    else if (split) kind = MOVE_HOLD;
    else            kind = MOVE_TOGGLE;
  end

  // Work out the next address for that kind of move.
  always_comb begin
    unique case (kind)
      MOVE_HOLD:   nxt = cur;
      MOVE_TOGGLE: nxt = cur ^ ONE;
      default: begin
        if (split) begin
          if (cur == A_LAST)      nxt = B_FIRST;
          else if (cur >= B_LAST) nxt = '0;
          else                    nxt = cur + ONE;
        end else begin
          if (cur >= P_LAST)      nxt = '0;
          else                    nxt = cur + ONE;
        end
      end
    endcase
  end
endmodule

// File: rtl/rap_region.sv
module rap_region #(
  parameter int ADDR_W = 8,
  parameter int REGS_PER_PORT = 11,
  parameter int B_BASE = 16
) (
  input  logic [ADDR_W-1:0] a,
  input  logic              split,
  output logic              ok
);
  localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(REGS_PER_PORT - 1);
  localparam logic [ADDR_W-1:0] B_FIRST = ADDR_W'(B_BASE);
  localparam logic [ADDR_W-1:0] B_LAST  = ADDR_W'(B_BASE + REGS_PER_PORT - 1);
  localparam logic [ADDR_W-1:0] P_LAST  = ADDR_W'(2 * REGS_PER_PORT - 1);

  logic in_a, in_b, in_p;

  always_comb begin
    in_a = (a <= A_LAST);
    in_b = (a >= B_FIRST) && (a <= B_LAST);
    in_p = (a <= P_LAST);
    ok   = split ? (in_a || in_b) : in_p;
  end
endmodule

// File: rtl/reg_addr_ptr.sv
module reg_addr_ptr #(
  parameter int ADDR_W = 8,
  parameter int REGS_PER_PORT = 11,
  parameter int B_BASE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  input  logic              layout_split,
  input  logic              hold_ptr,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_valid
);
  localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(REGS_PER_PORT - 1);
  localparam logic [ADDR_W-1:0] B_FIRST = ADDR_W'(B_BASE);
  localparam logic [ADDR_W-1:0] B_LAST  = ADDR_W'(B_BASE + REGS_PER_PORT - 1);
  localparam logic [ADDR_W-1:0] P_LAST  = ADDR_W'(2 * REGS_PER_PORT - 1);

  logic [ADDR_W-1:0] ptr_q, step_addr, ptr_d;
  logic              valid_q, valid_d;

  rap_step #(.ADDR_W(ADDR_W), .REGS_PER_PORT(REGS_PER_PORT), .B_BASE(B_BASE)) u_step (
    .cur(ptr_q), .split(layout_split), .hold(hold_ptr), .nxt(step_addr)
  );

  // A load takes priority over a step; with neither, the pointer holds.
  always_comb begin
    if (load)      ptr_d = load_addr;
    else if (step) ptr_d = step_addr;
    else           ptr_d = ptr_q;
  end

  rap_region #(.ADDR_W(ADDR_W), .REGS_PER_PORT(REGS_PER_PORT), .B_BASE(B_BASE)) u_region (
    .a(ptr_d), .split(layout_split), .ok(valid_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      valid_q <= 1'b1;
    end else begin
      ptr_q   <= ptr_d;
      valid_q <= valid_d;
    end
  end

  assign addr       = ptr_q;
  assign addr_valid = valid_q;

  p_load_wins_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> addr == $past(load_addr));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(addr));
  p_split_jump_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !load && layout_split && !hold_ptr && addr == A_LAST) |=> addr == B_FIRST);
  p_split_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !load && layout_split && !hold_ptr && addr >= B_LAST) |=> addr == '0);
  p_pair_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !layout_split && !hold_ptr && addr >= P_LAST) |=> addr == '0);
  p_split_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    (step && !load && layout_split && hold_ptr) |=> $stable(addr));
  p_pair_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !layout_split && hold_ptr) |=> addr == ($past(addr) ^ ADDR_W'(1)));
  p_hole_invalid_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && !step && layout_split && addr > A_LAST && addr < B_FIRST) |=> !addr_valid);
  p_pair_range_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && !step && !layout_split) |=> addr_valid == (addr <= P_LAST));
endmodule

// File: tb/reg_addr_ptr_bench.sv
module reg_addr_ptr_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [7:0] load_addr = '0;
  logic       step = 1'b0;
  logic       layout_split = 1'b1;
  logic       hold_ptr = 1'b0;
  logic [7:0] addr;
  logic       addr_valid;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  reg_addr_ptr u_reg_addr_ptr (
    .clk(clk), .rst(rst), .load(load), .load_addr(load_addr), .step(step),
    .layout_split(layout_split), .hold_ptr(hold_ptr),
    .addr(addr), .addr_valid(addr_valid)
  );

  typedef struct packed {
    logic       ld;
    logic [7:0] la;
    logic       st;
    logic       sp;
    logic       ho;
    logic [7:0] ea;
    logic       ev;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h09, 1'b0, 1'b1, 1'b0, 8'h09, 1'b1, 4'd2}, // R2 load in split map
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h0A, 1'b1, 4'd3}, // R3 plain increment
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h10, 1'b1, 4'd3}, // R3 jump over the hole
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h11, 1'b1, 4'd3}, // R3 increment in port B
    '{1'b1, 8'h19, 1'b0, 1'b1, 1'b0, 8'h19, 1'b1, 4'd2}, // R2
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h1A, 1'b1, 4'd3}, // R3
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 4'd4}, // R4 wrap at 1Ah
    '{1'b1, 8'h12, 1'b0, 1'b0, 1'b0, 8'h12, 1'b1, 4'd2}, // R2 paired map
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h13, 1'b1, 4'd5}, // R5 increment
    '{1'b1, 8'h15, 1'b0, 1'b0, 1'b0, 8'h15, 1'b1, 4'd2}, // R2
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd5}, // R5 wrap at 15h
    '{1'b1, 8'h12, 1'b0, 1'b0, 1'b1, 8'h12, 1'b1, 4'd2}, // R2
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h13, 1'b1, 4'd7}, // R7 even to odd
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h12, 1'b1, 4'd7}, // R7 back to even
    '{1'b1, 8'h15, 1'b0, 1'b0, 1'b1, 8'h15, 1'b1, 4'd2}, // R2
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h14, 1'b1, 4'd7}, // R7 starting on odd
    '{1'b1, 8'h09, 1'b0, 1'b1, 1'b1, 8'h09, 1'b1, 4'd2}, // R2
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h09, 1'b1, 4'd6}, // R6 frozen
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h09, 1'b1, 4'd6}, // R6 still frozen
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h09, 1'b1, 4'd9}, // R9 idle holds
    '{1'b1, 8'h0C, 1'b0, 1'b1, 1'b0, 8'h0C, 1'b0, 4'd8}, // R8 hole is invalid
    '{1'b1, 8'h16, 1'b0, 1'b0, 1'b0, 8'h16, 1'b0, 4'd8}, // R8 beyond paired map
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 4'd5}, // R5 wrap from above end
    '{1'b1, 8'h16, 1'b0, 1'b1, 1'b0, 8'h16, 1'b1, 4'd8}, // R8 16h valid in split map
    '{1'b1, 8'h1B, 1'b0, 1'b1, 1'b0, 8'h1B, 1'b0, 4'd8}, // R8 beyond split map
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 4'd4}, // R4 wrap from above end
    '{1'b1, 8'h0B, 1'b0, 1'b0, 1'b0, 8'h0B, 1'b1, 4'd8}, // R8 configuration alias
    '{1'b1, 8'h05, 1'b1, 1'b1, 1'b0, 8'h05, 1'b1, 4'd2}, // R2 load beats step
    '{1'b1, 8'h0C, 1'b0, 1'b0, 1'b0, 8'h0C, 1'b1, 4'd8}, // R8 0Ch valid when paired
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h0C, 1'b0, 4'd9}, // R9 layout switch, no step
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h0C, 1'b1, 4'd9}  // R9 switch back
  };

  task automatic check(input [7:0] ea, input logic ev, input int rq);
    checks++;
    if (addr !== ea || addr_valid !== ev) begin
      fails++;
      $display("FAIL R%0d: addr=%h valid=%b expected addr=%h valid=%b",
               rq, addr, addr_valid, ea, ev);
    end
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(8'h00, 1'b1, 1); // R1 during reset
    rst = 1'b0;
    @(negedge clk);
    check(8'h00, 1'b1, 1); // R1 after release

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      load = VECS[i].ld;
      load_addr = VECS[i].la;
      step = VECS[i].st;
      layout_split = VECS[i].sp;
      hold_ptr = VECS[i].ho;
      @(posedge clk);
      #1;
      check(VECS[i].ea, VECS[i].ev, int'(VECS[i].rq));
    end

    // R1: a reset in the middle of a run clears a loaded pointer.
    @(negedge clk);
    load = 1'b1; load_addr = 8'h1C; step = 1'b0; layout_split = 1'b1;
    @(negedge clk);
    load = 1'b0; rst = 1'b1;
    @(posedge clk);
    #1;
    check(8'h00, 1'b1, 1);
    @(negedge clk);
    rst = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #20000;
    fails++;
    checks++;
    $display("FAIL R1: watchdog expired, actual=hang expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule